// File: doc/BRIEF.md
# Multicore Cluster Power Sequencer

This block controls power for a cluster of up to four processor cores through a small memory-mapped register set. Software asks for a sleeping core to be powered up by setting that core's bit in a wake register. The bit stays set until the core has been brought up. The block powers the core, waits a programmable settle time, removes isolation and then releases the core's reset. Software polls the wake register until it reads zero.

Software can also arm standby on a running core by writing its control register. Nothing changes at that moment. When the core later signals wait-for-interrupt (WFI), the block asserts the core's reset, then isolation, and then removes power. A packed status register shows each core's present power state. A debug reset enable register holds a few enable flags for the debug logic around the cluster.

The register bus is a single-cycle select/write strobe with combinational read data. Each core gets its own sequencer, and the per-core power-enable, isolation and reset outputs drive the core wrappers directly.

Top module: `cluster_pwr_ctrl`

## Requirements
- R1: After reset, core 0 is running (power on, isolation off, reset released) and every other core is in standby (power off, isolation on, reset held). The wake register reads 0. The settle register reads its default (8). Every control register reads 0.
- R2: Writing 1 to bit n of the wake register (offset 0x10) sets that bit if core n is not running. The bit reads 1 until the edge on which core n's reset is released, and it reads 0 from that cycle on. Several cores may be woken by one write.
- R3: A wake request runs the steps in a fixed order. Power-enable rises one cycle after the wake bit is set. Isolation is released after max(S,1) cycles of settle, where S is bits [7:0] of the settle register at offset 0x20. Reset is released one cycle after isolation.
- R4: The status register (offset 0x40) holds a 2-bit field for core n at bits [4n+1:4n]. The codes are 0 for running, 1 for powering up, 2 for powering down and 3 for standby. Code 3 is shown exactly when the core's power is off.
- R5: Core n has a control register at offset 0x100 + 0x10*n with a 2-bit mode field in bits [1:0]. Writing mode 3 arms standby and leaves the core's outputs unchanged.
- R6: A WFI from a running core with standby armed asserts the core's reset on the next cycle, then isolation one cycle later, then removes power one cycle after that. The mode field reads 0 from the cycle the reset is asserted.
- R7: A WFI from a running core without standby armed leaves the core running. A wake write to a running core has no effect, and its bit reads 0 at once.
- R8: The debug reset register (offset 0x180) stores bit 24 (reset from other cores), bits 20+n for each core n (per-core reset enable) and bit 19 (peripheral reset enable). It resets to 0.
- R9: Register bits not listed above read 0 and ignore writes. Unmapped offsets read 0 and ignore writes. Control offsets of cores beyond the configured count are unmapped.
- R10: On every core, a released reset implies power on and isolation off, and isolation off implies power on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | AW (12) | Byte offset of the register |
| bus_wdata | input | DW (32) | Write data |
| bus_rdata | output | DW (32) | Read data, valid in the cycle of a read strobe |
| core_wfi | input | N_CORES (4) | Wait-for-interrupt indication per core |
| core_pwr_en | output | N_CORES (4) | Power switch enable per core |
| core_iso | output | N_CORES (4) | Output isolation enable per core |
| core_rst_n | output | N_CORES (4) | Active-low core reset per core |

## Verification
Some properties are checked on every cycle: the ordering of the power, isolation and reset edges in both directions, the link between the standby status code and the power-enable output, a wake bit dropping only when its core comes out of reset, and a WFI without standby armed never taking a core down. The bench scenarios cover what needs a known register history. These are the exact settle length set by the programmed count (including a count of zero), the field positions and codes in the status word, how the wake bits read while a request is pending, the masking of the debug and control registers, and writes to unmapped offsets being ignored.

// File: rtl/cpc_pkg.sv
// Shared types and constants of the cluster power sequencer.
package cpc_pkg;

    // Per-core sequencer states
    typedef enum logic [2:0] {
        ST_STBY,
        ST_UP_SETTLE,
        ST_UP_ISO,
        ST_RUN,
        ST_DN_RST,
        ST_DN_ISO
    } seq_state_t;

    // Status field codes seen by software
    localparam logic [1:0] STAT_RUN  = 2'd0;
    localparam logic [1:0] STAT_UP   = 2'd1;
    localparam logic [1:0] STAT_DN   = 2'd2;
    localparam logic [1:0] STAT_STBY = 2'd3;

    // Mode value that arms standby
    localparam logic [1:0] MODE_STBY = 2'd3;

    // Register offsets
    localparam int unsigned OFS_WAKE      = 'h10;
    localparam int unsigned OFS_SETTLE    = 'h20;
    localparam int unsigned OFS_STAT      = 'h40;
    localparam int unsigned OFS_CTRL_BASE = 'h100;
    localparam int unsigned OFS_CTRL_STEP = 'h10;
    localparam int unsigned OFS_DBG       = 'h180;

    // Debug register bit positions
    localparam int unsigned DBG_OTHER_BIT  = 24;
    localparam int unsigned DBG_CORE_BIT0  = 20;
    localparam int unsigned DBG_PERIPH_BIT = 19;

    // Status field stride in bits
    localparam int unsigned STAT_STRIDE = 4;

endpackage

// File: rtl/cpc_core_seq.sv
// Power sequencer for one core.
// Wake-up runs power on, then settle count, then isolation release, then
// reset release. Standby entry on an armed WFI runs reset, then isolation,
// then power off. Assumes wake_req is held until up_done is seen.
module cpc_core_seq
    import cpc_pkg::*;
#(
    parameter int unsigned SETTLE_W = 8,
    parameter bit          BOOT_RUN = 1'b0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wake_req,
    input  logic                stby_armed,
    input  logic                wfi,
    input  logic [SETTLE_W-1:0] settle,
    output logic                up_done,
    output logic                dn_start,
    output logic                pwr_en,
    output logic                iso,
    output logic                rst_out_n,
    output logic [1:0]          stat
);

    localparam seq_state_t RESET_ST = BOOT_RUN ? ST_RUN : ST_STBY;

    seq_state_t          state_q, state_d;
    logic [SETTLE_W-1:0] cnt_q, cnt_d;

    // Next-state and settle counter logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_STBY: begin
                if (wake_req) begin
                    state_d = ST_UP_SETTLE;
                    cnt_d   = settle;
                end
            end
            ST_UP_SETTLE: begin
                if (cnt_q <= SETTLE_W'(1)) state_d = ST_UP_ISO;
                else                       cnt_d   = cnt_q - SETTLE_W'(1);
            end
            ST_UP_ISO: state_d = ST_RUN;
            ST_RUN: begin
                if (wfi && stby_armed) state_d = ST_DN_RST;
            end
            ST_DN_RST: state_d = ST_DN_ISO;
            ST_DN_ISO: state_d = ST_STBY;
            default:   state_d = ST_STBY;
        endcase
    end

    // State and counter registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RESET_ST;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Output decode from the registered state
    always_comb begin
        pwr_en    = 1'b0;
        iso       = 1'b1;
        rst_out_n = 1'b0;
        stat      = STAT_STBY;
        unique case (state_q)
            ST_STBY: ;
            ST_UP_SETTLE: begin
                pwr_en = 1'b1;
                stat   = STAT_UP;
            end
            ST_UP_ISO: begin
                pwr_en = 1'b1;
                iso    = 1'b0;
                stat   = STAT_UP;
            end
            ST_RUN: begin
                pwr_en    = 1'b1;
                iso       = 1'b0;
                rst_out_n = 1'b1;
                stat      = STAT_RUN;
            end
            ST_DN_RST: begin
                pwr_en = 1'b1;
                iso    = 1'b0;
                stat   = STAT_DN;
            end
            ST_DN_ISO: begin
                pwr_en = 1'b1;
                stat   = STAT_DN;
            end
            default: ;
        endcase
    end

    // Handshake pulses toward the register block
    assign up_done  = (state_q == ST_UP_ISO);
    assign dn_start = (state_q == ST_RUN) && wfi && stby_armed;

endmodule

// File: rtl/cpc_regs.sv
// Register file of the cluster power sequencer.
// Holds the wake bits, settle count, per-core mode fields and debug enables.
// Read data is combinational in the cycle of the strobe. Assumes
// DW >= STAT_STRIDE*N_CORES and N_CORES <= 4.
module cpc_regs
    import cpc_pkg::*;
#(
    parameter int unsigned N_CORES    = 4,
    parameter int unsigned AW         = 12,
    parameter int unsigned DW         = 32,
    parameter int unsigned SETTLE_W   = 8,
    parameter int unsigned SETTLE_DEF = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bus_sel,
    input  logic                   bus_wr,
    input  logic [AW-1:0]          bus_addr,
    input  logic [DW-1:0]          bus_wdata,
    output logic [DW-1:0]          bus_rdata,
    input  logic [N_CORES-1:0]     up_done,
    input  logic [N_CORES-1:0]     dn_start,
    input  logic [2*N_CORES-1:0]   stat_flat,
    output logic [N_CORES-1:0]     wake_pend,
    output logic [N_CORES-1:0]     stby_arm,
    output logic [SETTLE_W-1:0]    settle
);

    localparam logic [AW-1:0] A_WAKE   = AW'(OFS_WAKE);
    localparam logic [AW-1:0] A_SETTLE = AW'(OFS_SETTLE);
    localparam logic [AW-1:0] A_STAT   = AW'(OFS_STAT);
    localparam logic [AW-1:0] A_DBG    = AW'(OFS_DBG);

    function automatic logic [DW-1:0] dbg_mask_f();
        logic [DW-1:0] m;
        m = '0;
        m[DBG_OTHER_BIT]  = 1'b1;
        m[DBG_PERIPH_BIT] = 1'b1;
        for (int i = 0; i < int'(N_CORES); i++) m[DBG_CORE_BIT0 + i] = 1'b1;
        return m;
    endfunction

    localparam logic [DW-1:0] DBG_MASK = dbg_mask_f();

    logic                     wr_en;
    logic [N_CORES-1:0]       hit_ctrl;
    logic [N_CORES-1:0][1:0]  mode_q;
    logic [SETTLE_W-1:0]      settle_q;
    logic [DW-1:0]            dbg_q;

    assign wr_en = bus_sel && bus_wr;

    // Per-core control offset decode
    for (genvar i = 0; i < N_CORES; i++) begin : g_dec
        assign hit_ctrl[i] = (bus_addr == AW'(OFS_CTRL_BASE + OFS_CTRL_STEP * i));
        assign stby_arm[i] = (mode_q[i] == MODE_STBY);
    end

    // Wake bits: set on write to a non-running core, clear on reset release
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wake_pend <= '0;
        end else begin
            for (int i = 0; i < int'(N_CORES); i++) begin
                if (up_done[i])
                    wake_pend[i] <= 1'b0;
                else if (wr_en && bus_addr == A_WAKE && bus_wdata[i] &&
                         stat_flat[2*i +: 2] != STAT_RUN)
                    wake_pend[i] <= 1'b1;
            end
        end
    end

    // Mode fields: software write, cleared when standby entry starts
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
        end else begin
            for (int i = 0; i < int'(N_CORES); i++) begin
                if (dn_start[i])
                    mode_q[i] <= 2'd0;
                else if (wr_en && hit_ctrl[i])
                    mode_q[i] <= bus_wdata[1:0];
            end
        end
    end

    // Settle count and debug enables
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            settle_q <= SETTLE_W'(SETTLE_DEF);
            dbg_q    <= '0;
        end else if (wr_en) begin
            if (bus_addr == A_SETTLE) settle_q <= bus_wdata[SETTLE_W-1:0];
            if (bus_addr == A_DBG)    dbg_q    <= bus_wdata & DBG_MASK;
        end
    end

    assign settle = settle_q;

    // Read data multiplexer
    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            if (bus_addr == A_WAKE) begin
                bus_rdata[N_CORES-1:0] = wake_pend;
            end else if (bus_addr == A_SETTLE) begin
                bus_rdata[SETTLE_W-1:0] = settle_q;
            end else if (bus_addr == A_STAT) begin
                for (int i = 0; i < int'(N_CORES); i++)
                    bus_rdata[STAT_STRIDE*i +: 2] = stat_flat[2*i +: 2];
            end else if (bus_addr == A_DBG) begin
                bus_rdata = dbg_q;
            end else begin
                for (int i = 0; i < int'(N_CORES); i++)
                    if (hit_ctrl[i]) bus_rdata[1:0] = mode_q[i];
            end
        end
    end

endmodule

// File: rtl/cluster_pwr_ctrl.sv
// Top of the cluster power sequencer: one register block and one sequencer
// per core. Core 0 comes out of reset running, all others in standby.
module cluster_pwr_ctrl
    import cpc_pkg::*;
#(
    parameter int unsigned N_CORES    = 4,
    parameter int unsigned AW         = 12,
    parameter int unsigned DW         = 32,
    parameter int unsigned SETTLE_W   = 8,
    parameter int unsigned SETTLE_DEF = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic [AW-1:0]      bus_addr,
    input  logic [DW-1:0]      bus_wdata,
    output logic [DW-1:0]      bus_rdata,
    input  logic [N_CORES-1:0] core_wfi,
    output logic [N_CORES-1:0] core_pwr_en,
    output logic [N_CORES-1:0] core_iso,
    output logic [N_CORES-1:0] core_rst_n
);

    logic [N_CORES-1:0]   up_done;
    logic [N_CORES-1:0]   dn_start;
    logic [N_CORES-1:0]   wake_pend;
    logic [N_CORES-1:0]   stby_arm;
    logic [2*N_CORES-1:0] stat_flat;
    logic [SETTLE_W-1:0]  settle;

    cpc_regs #(
        .N_CORES    (N_CORES),
        .AW         (AW),
        .DW         (DW),
        .SETTLE_W   (SETTLE_W),
        .SETTLE_DEF (SETTLE_DEF)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .up_done   (up_done),
        .dn_start  (dn_start),
        .stat_flat (stat_flat),
        .wake_pend (wake_pend),
        .stby_arm  (stby_arm),
        .settle    (settle)
    );

    // One sequencer per core; core 0 boots running
    for (genvar i = 0; i < N_CORES; i++) begin : g_core
        cpc_core_seq #(
            .SETTLE_W (SETTLE_W),
            .BOOT_RUN (i == 0)
        ) u_seq (
            .clk        (clk),
            .rst_n      (rst_n),
            .wake_req   (wake_pend[i]),
            .stby_armed (stby_arm[i]),
            .wfi        (core_wfi[i]),
            .settle     (settle),
            .up_done    (up_done[i]),
            .dn_start   (dn_start[i]),
            .pwr_en     (core_pwr_en[i]),
            .iso        (core_iso[i]),
            .rst_out_n  (core_rst_n[i]),
            .stat       (stat_flat[2*i +: 2])
        );
    end

endmodule

// File: rtl/cpc_checker.sv
// Cycle-level checks of the cluster power sequencer, bound to its top.
// Assumes the signals named in the bind exist inside cluster_pwr_ctrl.
module cpc_checker #(
    parameter int unsigned N_CORES = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic [N_CORES-1:0] core_wfi,
    input logic [N_CORES-1:0] core_pwr_en,
    input logic [N_CORES-1:0] core_iso,
    input logic [N_CORES-1:0] core_rst_n,
    input logic [N_CORES-1:0] wake_pend,
    input logic [N_CORES-1:0] stby_arm,
    input logic [2*N_CORES-1:0] stat_flat
);

    for (genvar i = 0; i < N_CORES; i++) begin : g_chk
        // R10: a released reset needs a live, unisolated core
        a_r10_rst_needs_live: assert property (@(posedge clk) disable iff (!rst_n)
            core_rst_n[i] |-> (core_pwr_en[i] && !core_iso[i]));

        // R10: isolation off needs power on
        a_r10_iso_needs_pwr: assert property (@(posedge clk) disable iff (!rst_n)
            !core_iso[i] |-> core_pwr_en[i]);

        // R3: reset release follows a cycle with isolation already off
        a_r3_rst_after_iso: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(core_rst_n[i]) |-> $past(!core_iso[i]));

        // R6: reset goes low while isolation is still off
        a_r6_rst_first: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(core_rst_n[i]) |-> (!core_iso[i] && core_pwr_en[i]));

        // R6: power drops only after isolation was on
        a_r6_pwr_last: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(core_pwr_en[i]) |-> ($past(core_iso[i]) && core_iso[i]));

        // R4: standby code shown exactly when power is off
        a_r4_stby_code: assert property (@(posedge clk) disable iff (!rst_n)
            (stat_flat[2*i +: 2] == 2'd3) == !core_pwr_en[i]);

        // R2: a wake bit clears only as the core leaves reset
        a_r2_wake_clear: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(wake_pend[i]) |-> core_rst_n[i]);

        // R7: WFI without standby armed keeps the core running
        a_r7_wfi_unarmed: assert property (@(posedge clk) disable iff (!rst_n)
            (core_rst_n[i] && core_wfi[i] && !stby_arm[i]) |=> core_rst_n[i]);
    end

endmodule

bind cluster_pwr_ctrl cpc_checker #(.N_CORES(N_CORES)) u_cpc_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .core_wfi    (core_wfi),
    .core_pwr_en (core_pwr_en),
    .core_iso    (core_iso),
    .core_rst_n  (core_rst_n),
    .wake_pend   (wake_pend),
    .stby_arm    (stby_arm),
    .stat_flat   (stat_flat)
);

// File: tb/cluster_pwr_ctrl_bench.sv
// Scoreboard bench: driver tasks queue expected values, a monitor process
// compares them against the ports at the falling edge of the same cycle.
module cluster_pwr_ctrl_bench;

    localparam int N  = 4;
    localparam int AW = 12;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_sel, bus_wr;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata;
    logic [DW-1:0] bus_rdata;
    logic [N-1:0]  core_wfi;
    logic [N-1:0]  core_pwr_en, core_iso, core_rst_n;

    always #5 clk = ~clk;

    cluster_pwr_ctrl u_cluster_pwr_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_sel     (bus_sel),
        .bus_wr      (bus_wr),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .core_wfi    (core_wfi),
        .core_pwr_en (core_pwr_en),
        .core_iso    (core_iso),
        .core_rst_n  (core_rst_n)
    );

    typedef struct {
        int          kind;   // 0: read data, 1: core pins {pwr,iso,rst_n}
        int          core;
        logic [31:0] exp;
        string       req;
    } item_t;

    item_t exp_q[$];
    int    total = 0;
    int    bad   = 0;
    bit    done  = 0;

    // Monitor: pop and compare everything queued for this cycle
    always @(negedge clk) begin
        while (exp_q.size() > 0) begin
            item_t       it;
            logic [31:0] act;
            it = exp_q.pop_front();
            if (it.kind == 0) act = bus_rdata;
            else act = {29'd0, core_pwr_en[it.core], core_iso[it.core], core_rst_n[it.core]};
            total++;
            if (act !== it.exp) begin
                bad++;
                $display("FAIL %s kind=%0d core=%0d actual=%h expected=%h",
                         it.req, it.kind, it.core, act, it.exp);
            end
        end
    end

    task automatic bus_idle();
        bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_idle();
    endtask

    task automatic want_pins(input int c, input bit p, input bit i, input bit r, input string req);
        item_t it;
        it.kind = 1; it.core = c; it.exp = {29'd0, p, i, r}; it.req = req;
        exp_q.push_back(it);
    endtask

    task automatic probe(input logic [AW-1:0] a, input logic [31:0] e, input string req);
        item_t it;
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        it.kind = 0; it.core = 0; it.exp = e; it.req = req;
        exp_q.push_back(it);
        @(posedge clk); #1;
        bus_idle();
    endtask

    task automatic idle(input int k);
        repeat (k) begin @(posedge clk); #1; end
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
    endtask

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        bus_idle();
        core_wfi = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        want_pins(0, 1, 0, 1, "R1");
        for (int c = 1; c < N; c++) want_pins(c, 0, 1, 0, "R1");
        probe('h40, 32'h0000_3330, "R1");
        probe('h10, 32'h0, "R1");
        probe('h20, 32'h8, "R1");
        probe('h100, 32'h0, "R1");

        // R9 unmapped and unused bits
        do_write('h30, 32'hFFFF_FFFF);
        probe('h30, 32'h0, "R9");
        do_write('h140, 32'h3);
        probe('h140, 32'h0, "R9");
        do_write('h20, 32'h0000_0F04);
        probe('h20, 32'h4, "R9");

        // R8 debug register mask
        do_write('h180, 32'hFFFF_FFFF);
        probe('h180, 32'h01F8_0000, "R8");
        do_write('h180, 32'h0);
        probe('h180, 32'h0, "R8");

        // R7 wake to a running core, WFI without arming
        do_write('h10, 32'h1);
        want_pins(0, 1, 0, 1, "R7");
        probe('h10, 32'h0, "R7");
        core_wfi[0] = 1'b1;
        idle(3);
        want_pins(0, 1, 0, 1, "R7");
        probe('h40, 32'h0000_3330, "R7");
        core_wfi[0] = 1'b0;

        // R2/R3/R4 wake core 1 with settle 4
        do_write('h10, 32'h2);                 // set on this edge
        want_pins(1, 0, 1, 0, "R3");
        probe('h10, 32'h2, "R2");
        want_pins(1, 1, 1, 0, "R3");
        probe('h40, 32'h0000_3310, "R4");
        idle(2);
        want_pins(1, 1, 1, 0, "R3");           // last settle cycle
        probe('h10, 32'h2, "R2");
        want_pins(1, 1, 0, 0, "R3");           // isolation released
        probe('h40, 32'h0000_3310, "R4");
        want_pins(1, 1, 0, 1, "R3");           // reset released
        probe('h10, 32'h0, "R2");
        probe('h40, 32'h0000_3300, "R4");

        // R5 arming does not act at once; R6 standby entry on WFI
        do_write('h110, 32'hFFFF_FFFF);
        want_pins(1, 1, 0, 1, "R5");
        probe('h110, 32'h3, "R5");
        core_wfi[1] = 1'b1;
        probe('h40, 32'h0000_3300, "R6");
        core_wfi[1] = 1'b0;
        want_pins(1, 1, 0, 0, "R6");
        probe('h110, 32'h0, "R6");
        want_pins(1, 1, 1, 0, "R6");
        probe('h40, 32'h0000_3320, "R4");
        want_pins(1, 0, 1, 0, "R6");
        probe('h40, 32'h0000_3330, "R6");

        // R2 two cores woken together, settle 2: polled cycle by cycle
        do_write('h20, 32'h2);
        do_write('h10, 32'h6);
        for (int k = 1; k <= 5; k++) probe('h10, (k < 5) ? 32'h6 : 32'h0, "R2");
        probe('h40, 32'h0000_3000, "R4");

        // R3 settle count zero behaves as one
        do_write('h20, 32'h0);
        do_write('h10, 32'h8);
        for (int k = 1; k <= 4; k++) probe('h10, (k < 4) ? 32'h8 : 32'h0, "R3");
        want_pins(3, 1, 0, 1, "R3");
        probe('h40, 32'h0, "R4");

        done = 1;
        summary();
        $finish;
    end

endmodule